// File: doc/BRIEF.md
# Serial programming host sequencer

This block runs on the host side of an in-system programming link. It drives a target's reset, serial clock and serial data-in pins, reads the target's serial data-out pin, and walks through a byte image to erase, program and verify the target's flash and EEPROM. A programming run begins with a reset pulse, a power-up wait and an enable frame. If erase is requested, a chip erase follows, then the erase delay, a second reset pulse and a second enable frame. After that the image is streamed in one byte at a time, and each byte is written with its own 32-bit instruction frame.

Completion of each write is detected by reading the written location back until it shows the intended value. Some values cannot be told apart from the target's busy read-back: EEPROM 0x00 and 0xFF, and flash 0xFF. For these the block instead waits a fixed minimum write time. Each completed byte is then read once more for verification. A verify mismatch stops the run with an error code, and so does a target that never reports completion within a polling limit. A run that finishes cleanly ends with reset released, which lets the target start normal operation. Every delay and every serial clock phase length is a parameter counted in host clock cycles.

Top module: `isp_host_seq`

## Requirements
- R1: Out of reset and while idle, `tgt_rst`, `tgt_sck`, `busy`, `done`, `err` and `img_req` are all 0.
- R2: After `start`, `tgt_rst` is high for exactly RST_PULSE cycles while `tgt_sck` is low. `tgt_rst` then stays low for at least T_PWRUP cycles before the first `tgt_sck` rise. The same pulse and wait are repeated after a chip erase.
- R3: Frames are 32 bits, most significant bit first. Each `tgt_sck` high phase lasts exactly SCK_HI cycles and each low phase at least SCK_LO cycles. `tgt_mosi` changes only while `tgt_sck` is low. `tgt_miso` is sampled as `tgt_sck` rises.
- R4: The first frame after every reset pulse is the enable frame: bytes 0xAC, 0x53, 0x00, 0x00.
- R5: With `erase_en` captured at `start`, the enable frame is followed by the erase frame (0xAC, 0x80, 0x00, 0x00), then T_ERASE cycles of wait, then the R2 pulse and wait, then a new enable frame. Only after that are any writes sent.
- R6: `img_req` is high while the block waits for an image entry. An entry is taken in a cycle where both `img_req` and `img_ack` are high. An entry taken with `img_end` high ends the run.
- R7: Write frames are: flash `{0100,H,000}`,`{0000000,a8}`,`a[7:0]`,data, and EEPROM 0xC0,0x00,`{00,a[5:0]}`,data. Read frames use first bytes `{0010,H,000}` and 0xA0 with the same address bytes, and the data returned in the fourth byte. H is `img_hi`.
- R8: In a run with erase, entries whose data is 0xFF produce no frame.
- R9: For all other values, read frames to the written location repeat until the returned byte equals the data. After POLL_MAX reads that do not match, the block stops with `err`=1 and `err_code`=1.
- R10: For EEPROM data 0x00 or 0xFF, and for flash data 0xFF, no read is sent until T_WPROG cycles after the write frame ends.
- R11: After completion one verify read is sent. If its value differs from the data, the block stops with `err`=1, `err_code`=2 and `tgt_rst` held low. The error state holds until the next `start`.
- R12: After the last entry `done`=1, `tgt_rst`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run |
| erase_en | input | 1 | Run a chip erase first (captured at start) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed cleanly |
| err | output | 1 | Run stopped on an error |
| err_code | output | 2 | 1 = completion never seen, 2 = verify mismatch |
| img_req | output | 1 | Waiting for an image entry |
| img_ack | input | 1 | Image entry valid |
| img_end | input | 1 | No more entries |
| img_eeprom | input | 1 | Entry targets EEPROM (else flash) |
| img_hi | input | 1 | Flash high byte of the word |
| img_addr | input | 9 | Flash word address or EEPROM address (bits 5:0) |
| img_data | input | 8 | Byte to program |
| tgt_rst | output | 1 | Target reset pin |
| tgt_sck | output | 1 | Target serial clock |
| tgt_mosi | output | 1 | Target serial data in |
| tgt_miso | input | 1 | Target serial data out |

## Verification
A wrong state in the frame engine shows up in the next few SCK phases as a bad phase width, MOSI moving while SCK is high, or a frame the target cannot decode. A wrong state in the sequencer shows up differently. A write may arrive while the target is still busy. A fixed-wait value may be read back too early. A byte equal to 0xFF may be written after an erase. Any of these is visible within one frame time, or when target memory is compared at the end of the run. Timeouts and verify failures are forced through a target model that never finishes a write or that stores a corrupted byte, and they must show the matching `err_code`.

// File: rtl/isp_host_seq.sv
module isp_host_seq #(
  parameter int unsigned SCK_LO    = 4,
  parameter int unsigned SCK_HI    = 8,
  parameter int unsigned RST_PULSE = 64,
  parameter int unsigned T_PWRUP   = 4_000_000,
  parameter int unsigned T_ERASE   = 3_600_000,
  parameter int unsigned T_WPROG   = 1_800_000,
  parameter int unsigned POLL_MAX  = 64,
  parameter int unsigned TMR_W     = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       erase_en,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [1:0] err_code,
  output logic       img_req,
  input  logic       img_ack,
  input  logic       img_end,
  input  logic       img_eeprom,
  input  logic       img_hi,
  input  logic [8:0] img_addr,
  input  logic [7:0] img_data,
  output logic       tgt_rst,
  output logic       tgt_sck,
  output logic       tgt_mosi,
  input  logic       tgt_miso
);
  localparam int unsigned PH_MAX = (SCK_LO > SCK_HI) ? SCK_LO : SCK_HI;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned PC_W   = $clog2(POLL_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RPUL, S_PWAIT, S_XFER, S_AEN, S_EWAIT, S_FETCH,
    S_AWR, S_WWAIT, S_APOLL, S_AVER, S_DONE, S_ERR
  } st_t;

  st_t st, ret;

  // serial frame engine
  logic            ld, fin, act, ph_hi;
  logic [31:0]     ld_w, sh;
  logic [4:0]      bitn;
  logic [PH_W-1:0] pc;
  logic [7:0]      rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; bitn <= '0; ph_hi <= 1'b0; act <= 1'b0;
      fin <= 1'b0; pc <= '0; rx <= '0;
    end else begin
      fin <= 1'b0;
      if (ld) begin
        sh <= ld_w; bitn <= '0; ph_hi <= 1'b0; pc <= '0; act <= 1'b1;
      end else if (act) begin
        if (!ph_hi) begin
          if (pc == PH_W'(SCK_LO - 1)) begin
            ph_hi <= 1'b1;
            pc    <= '0;
            rx    <= {rx[6:0], tgt_miso};
          end else pc <= pc + 1'b1;
        end else if (pc == PH_W'(SCK_HI - 1)) begin
          ph_hi <= 1'b0;
          pc    <= '0;
          sh    <= {sh[30:0], 1'b0};
          bitn  <= bitn + 1'b1;
          if (bitn == 5'd31) begin
            act <= 1'b0;
            fin <= 1'b1;
          end
        end else pc <= pc + 1'b1;
      end
    end
  end

  assign tgt_sck  = act & ph_hi;
  assign tgt_mosi = act & sh[31];

  // sequencer
  logic [TMR_W-1:0] tmr;
  logic [PC_W-1:0]  polls;
  logic             do_er, erased, cur_ee, cur_hi, fixed_w;
  logic [8:0]       cur_a;
  logic [7:0]       cur_d;

  assign fixed_w = cur_ee ? (cur_d == 8'h00 || cur_d == 8'hFF) : (cur_d == 8'hFF);

  function automatic logic [31:0] rd_word(input logic ee, input logic hi, input logic [8:0] a);
    return ee ? {8'hA0, 8'h00, 2'b00, a[5:0], 8'h00}
              : {4'b0010, hi, 3'b000, 7'd0, a[8], a[7:0], 8'h00};
  endfunction

  function automatic logic [31:0] wr_word(input logic ee, input logic hi, input logic [8:0] a,
                                          input logic [7:0] d);
    return ee ? {8'hC0, 8'h00, 2'b00, a[5:0], d}
              : {4'b0100, hi, 3'b000, 7'd0, a[8], a[7:0], d};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE; tmr <= '0; polls <= '0;
      do_er <= 1'b0; erased <= 1'b0; cur_ee <= 1'b0; cur_hi <= 1'b0;
      cur_a <= '0; cur_d <= '0; ld <= 1'b0; ld_w <= '0; err_code <= '0;
    end else begin
      ld <= 1'b0;
      case (st)
        S_IDLE, S_DONE, S_ERR:
          if (start) begin
            do_er    <= erase_en;
            erased   <= 1'b0;
            err_code <= '0;
            tmr      <= '0;
            st       <= S_RPUL;
          end
        S_RPUL:
          if (tmr == TMR_W'(RST_PULSE - 1)) begin
            tmr <= '0;
            st  <= S_PWAIT;
          end else tmr <= tmr + 1'b1;
        S_PWAIT:
          if (tmr == TMR_W'(T_PWRUP - 1)) begin
            tmr  <= '0;
            ld   <= 1'b1;
            ld_w <= 32'hAC53_0000;
            ret  <= S_AEN;
            st   <= S_XFER;
          end else tmr <= tmr + 1'b1;
        S_XFER:
          if (fin) st <= ret;
        S_AEN:
          if (do_er && !erased) begin
            ld   <= 1'b1;
            ld_w <= 32'hAC80_0000;
            ret  <= S_EWAIT;
            st   <= S_XFER;
          end else st <= S_FETCH;
        S_EWAIT:
          if (tmr == TMR_W'(T_ERASE - 1)) begin
            tmr    <= '0;
            erased <= 1'b1;
            st     <= S_RPUL;
          end else tmr <= tmr + 1'b1;
        S_FETCH:
          if (img_ack) begin
            if (img_end) st <= S_DONE;
            else begin
              cur_ee <= img_eeprom;
              cur_hi <= img_hi;
              cur_a  <= img_addr;
              cur_d  <= img_data;
              if (!(erased && img_data == 8'hFF)) begin
                ld   <= 1'b1;
                ld_w <= wr_word(img_eeprom, img_hi, img_addr, img_data);
                ret  <= S_AWR;
                st   <= S_XFER;
              end
            end
          end
        S_AWR: begin
          tmr <= '0;
          if (fixed_w) st <= S_WWAIT;
          else begin
            polls <= PC_W'(1);
            ld    <= 1'b1;
            ld_w  <= rd_word(cur_ee, cur_hi, cur_a);
            ret   <= S_APOLL;
            st    <= S_XFER;
          end
        end
        S_WWAIT:
          if (tmr == TMR_W'(T_WPROG - 1)) begin
            tmr  <= '0;
            ld   <= 1'b1;
            ld_w <= rd_word(cur_ee, cur_hi, cur_a);
            ret  <= S_AVER;
            st   <= S_XFER;
          end else tmr <= tmr + 1'b1;
        S_APOLL:
          if (rx == cur_d) begin
            ld   <= 1'b1;
            ld_w <= rd_word(cur_ee, cur_hi, cur_a);
            ret  <= S_AVER;
            st   <= S_XFER;
          end else if (polls == PC_W'(POLL_MAX)) begin
            err_code <= 2'd1;
            st       <= S_ERR;
          end else begin
            polls <= polls + 1'b1;
            ld    <= 1'b1;
            ld_w  <= rd_word(cur_ee, cur_hi, cur_a);
            ret   <= S_APOLL;
            st    <= S_XFER;
          end
        S_AVER:
          if (rx == cur_d) st <= S_FETCH;
          else begin
            err_code <= 2'd2;
            st       <= S_ERR;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tgt_rst = (st == S_RPUL) || (st == S_DONE);
  assign img_req = (st == S_FETCH);
  assign done    = (st == S_DONE);
  assign err     = (st == S_ERR);
  assign busy    = !(st == S_IDLE || st == S_DONE || st == S_ERR);
endmodule

// File: rtl/isp_host_seq_chk.sv
module isp_host_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       img_req,
  input logic       tgt_rst,
  input logic       tgt_sck,
  input logic       tgt_mosi
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tgt_sck);

  p_rst_no_sck_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !tgt_sck);

  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sck && $past(tgt_sck)) |-> $stable(tgt_mosi));

  p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    img_req |-> busy);

  p_code_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code != 2'd0));

  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  p_err_rst_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tgt_rst);

  p_done_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tgt_rst && !busy && !err));
endmodule

bind isp_host_seq isp_host_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .err_code(err_code), .img_req(img_req), .tgt_rst(tgt_rst), .tgt_sck(tgt_sck),
  .tgt_mosi(tgt_mosi)
);

// File: tb/isp_host_seq_tb_top.sv
`timescale 1ns/1ps
module isp_host_seq_tb_top;
  localparam int SLO = 3, SHI = 5, RP = 8, TPW = 200, TER = 400, TWP = 300, PMAX = 20;
  localparam int WR_BUSY = 250, ER_BUSY = 350;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, erase_en = 1'b0;
  logic busy, done, err, img_req, tgt_rst, tgt_sck, tgt_mosi;
  logic [1:0] err_code;
  logic img_ack = 1'b0, miso = 1'b0;
  int ip = 0, n_img = 0;
  logic       img_e [0:63];
  logic       img_h [0:63];
  logic [8:0] img_a [0:63];
  logic [7:0] img_d [0:63];

  always #2.5 clk = ~clk;

  wire        img_end    = (ip >= n_img);
  wire        img_eeprom = (ip < 64) ? img_e[ip] : 1'b0;
  wire        img_hi     = (ip < 64) ? img_h[ip] : 1'b0;
  wire [8:0]  img_addr   = (ip < 64) ? img_a[ip] : 9'd0;
  wire [7:0]  img_data   = (ip < 64) ? img_d[ip] : 8'd0;

  isp_host_seq #(.SCK_LO(SLO), .SCK_HI(SHI), .RST_PULSE(RP), .T_PWRUP(TPW), .T_ERASE(TER),
                 .T_WPROG(TWP), .POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .erase_en(erase_en), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .img_req(img_req), .img_ack(img_ack), .img_end(img_end),
    .img_eeprom(img_eeprom), .img_hi(img_hi), .img_addr(img_addr), .img_data(img_data),
    .tgt_rst(tgt_rst), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(miso));

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // image source
  always @(posedge clk) begin
    if (!rst_n) ip <= 0;
    else if (img_req && img_ack && ip < n_img) ip <= ip + 1;
  end

  // target model
  logic [7:0] fl [0:1023];
  logic [7:0] ee [0:63];
  logic [7:0] init_fl [0:1023];
  logic [7:0] init_ee [0:63];
  logic [7:0] exp_fl [0:1023];
  logic [7:0] exp_ee [0:63];
  int fault = 0;
  bit sess_er = 0;
  longint cyc = 0, busy_until = 0, busy_mid = 0, er_until = 0, t_rel = 0;
  int busy_idx = 0, n = 0, hi_len = 0, lo_len = 0, rst_hi = 0;
  bit busy_ee = 0, busy_fixed = 0, enabled = 0, wait_pw = 0, psck = 0, prst = 0;
  logic [31:0] rxw = '0;
  logic [7:0] osh = '0;
  int v_tim, v_rpw, v_pw, v_en, v_busy, v_fixed, v_erase, v_ff, n_wr, n_erase, n_rd, n_ph;

  task automatic t_read(input logic [23:0] h, output logic [7:0] v);
    int idx;
    bit is_ee;
    v = 8'h00;
    if (h[23:16] == 8'hA0) begin is_ee = 1; idx = int'(h[5:0]); end
    else if (h[23:20] == 4'b0010) begin is_ee = 0; idx = int'({h[8], h[7:0], h[19]}); end
    else return;
    n_rd++;
    v = is_ee ? ee[idx] : fl[idx];
    if (cyc < busy_until) begin
      if (busy_ee == is_ee && busy_idx == idx) begin
        if (busy_fixed) v_fixed++; else n_ph++;
        v = is_ee ? ((cyc < busy_mid) ? 8'h00 : 8'hFF) : 8'hFF;
      end else v_busy++;
    end
  endtask

  task automatic t_exec(input logic [31:0] w);
    logic [7:0] d;
    int idx;
    if (w[31:24] == 8'hAC && w[23:16] == 8'h53) begin enabled = 1; return; end
    if (!enabled) begin v_en++; return; end
    if (w[31:24] == 8'hA0 || w[31:28] == 4'b0010) return;
    if (cyc < busy_until || cyc < er_until) v_busy++;
    if (w[31:24] == 8'hAC && w[23:21] == 3'b100) begin
      for (int i = 0; i < 1024; i++) fl[i] = 8'hFF;
      for (int i = 0; i < 64; i++) ee[i] = 8'hFF;
      n_erase++;
      er_until = cyc + ER_BUSY;
      return;
    end
    d = (fault == 1) ? (w[7:0] ^ 8'h01) : w[7:0];
    if (w[31:24] == 8'hC0) begin
      idx = int'(w[13:8]); ee[idx] = d; busy_ee = 1;
      busy_fixed = (w[7:0] == 8'h00 || w[7:0] == 8'hFF);
    end else if (w[31:28] == 4'b0100) begin
      idx = int'({w[16], w[15:8], w[27]}); fl[idx] = d; busy_ee = 0;
      busy_fixed = (w[7:0] == 8'hFF);
    end else return;
    n_wr++;
    if (sess_er && w[7:0] == 8'hFF) v_ff++;
    busy_idx   = idx;
    busy_mid   = cyc + WR_BUSY / 2;
    busy_until = cyc + ((fault == 2) ? 1000000 : WR_BUSY);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) fl[i] = init_fl[i];
      for (int i = 0; i < 64; i++) ee[i] = init_ee[i];
      v_tim = 0; v_rpw = 0; v_pw = 0; v_en = 0; v_busy = 0; v_fixed = 0; v_erase = 0;
      v_ff = 0; n_wr = 0; n_erase = 0; n_rd = 0; n_ph = 0;
      enabled = 0; n = 0; miso = 1'b0; busy_until = 0; er_until = 0; wait_pw = 0;
      hi_len = 0; lo_len = 0; rst_hi = 0;
      img_ack <= 1'b0;
    end else begin
      img_ack <= ($urandom % 3) != 0;
      if (tgt_rst && !prst) begin
        enabled = 0; n = 0; rst_hi = 0;
        if (cyc < er_until) v_erase++;
      end
      if (tgt_rst) rst_hi++;
      if (!tgt_rst && prst) begin
        if (rst_hi != RP) v_rpw++;
        t_rel = cyc; wait_pw = 1;
      end
      if (tgt_sck && !psck) begin
        if (wait_pw) begin
          if (cyc - t_rel < TPW) v_pw++;
          wait_pw = 0;
        end
        if (lo_len < SLO) v_tim++;
        hi_len = 0;
        rxw = {rxw[30:0], tgt_mosi};
        n++;
        if (n == 32) begin t_exec(rxw); n = 0; end
      end
      if (!tgt_sck && psck) begin
        if (hi_len != SHI) v_tim++;
        lo_len = 0;
        if (n == 24) begin
          t_read(rxw[23:0], osh);
          miso = osh[7]; osh = {osh[6:0], 1'b0};
        end else if (n > 24) begin
          miso = osh[7]; osh = {osh[6:0], 1'b0};
        end
      end
      if (tgt_sck) hi_len++; else lo_len++;
    end
    prst = tgt_rst;
    psck = tgt_sck;
  end

  // stimulus helpers
  function automatic logic [7:0] pick_data();
    int r = $urandom % 8;
    return (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'($urandom);
  endfunction

  task automatic add_entry(input bit e, input bit h, input int a, input logic [7:0] d);
    img_e[n_img] = e; img_h[n_img] = h; img_a[n_img] = 9'(a); img_d[n_img] = d;
    n_img++;
  endtask

  task automatic add_random(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      bit e = ($urandom % 2) == 1;
      add_entry(e, ($urandom % 2) == 1, e ? int'($urandom % 64) : int'($urandom % 512), pick_data());
    end
  endtask

  task automatic rand_init();
    for (int i = 0; i < 1024; i++) init_fl[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) init_ee[i] = 8'($urandom);
  endtask

  task automatic run(input bit er, input int f, input int exp_code, input string tag);
    int k, exp_wr, bad;
    fault = f; sess_er = er; erase_en = er;
    exp_wr = 0;
    for (int i = 0; i < 1024; i++) exp_fl[i] = er ? 8'hFF : init_fl[i];
    for (int i = 0; i < 64; i++) exp_ee[i] = er ? 8'hFF : init_ee[i];
    for (int i = 0; i < n_img; i++) begin
      if (!(er && img_d[i] == 8'hFF)) begin
        exp_wr++;
        if (img_e[i]) exp_ee[img_a[i][5:0]] = img_d[i];
        else exp_fl[{img_a[i], img_h[i]}] = img_d[i];
      end
    end
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 0;
    while (!(done || err) && k < 60000) begin @(negedge clk); k++; end
    chk(k < 60000, {"R12 watchdog ", tag}, k, 60000);
    repeat (2) @(negedge clk);
    chk(v_rpw == 0, {"R2 pulse width ", tag}, v_rpw, 0);
    chk(v_pw == 0, {"R2 power-up wait ", tag}, v_pw, 0);
    chk(v_tim == 0, {"R3 sck phases ", tag}, v_tim, 0);
    chk(v_en == 0, {"R4 frame before enable ", tag}, v_en, 0);
    chk(n_erase == (er ? 1 : 0), {"R5 erase count ", tag}, n_erase, er ? 1 : 0);
    chk(v_erase == 0, {"R5 reset during erase ", tag}, v_erase, 0);
    chk(v_ff == 0, {"R8 0xFF written after erase ", tag}, v_ff, 0);
    chk(v_fixed == 0, {"R10 early read of fixed value ", tag}, v_fixed, 0);
    chk(v_busy == 0, {"R9 frame during busy ", tag}, v_busy, 0);
    chk(err_code == 2'(exp_code), {"R11 err_code ", tag}, err_code, exp_code);
    if (exp_code == 0) begin
      bad = 0;
      for (int i = 0; i < 1024; i++) if (fl[i] != exp_fl[i]) bad++;
      for (int i = 0; i < 64; i++) if (ee[i] != exp_ee[i]) bad++;
      chk(bad == 0, {"R7 memory image ", tag}, bad, 0);
      chk(n_wr == exp_wr, {"R6 write count ", tag}, n_wr, exp_wr);
      chk(done && tgt_rst && !busy && !err, {"R12 release ", tag}, {done, tgt_rst, busy, err}, 4'b1100);
    end else begin
      chk(err && !done && !tgt_rst && !tgt_sck, {"R11 stopped ", tag}, {err, done, tgt_rst}, 3'b100);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) init_fl[i] = 8'h00;
    for (int i = 0; i < 64; i++) init_ee[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tgt_rst && !tgt_sck && !busy && !done && !err && !img_req, "R1 idle pins",
        {tgt_rst, tgt_sck, busy, done, err, img_req}, 0);

    // erase run with random image, 0xFF entries must be skipped (R8)
    rand_init(); n_img = 0; add_random(20);
    add_entry(1'b1, 1'b0, 3, 8'hFF); add_entry(1'b0, 1'b1, 7, 8'hFF);
    run(1'b1, 0, 0, "erase");

    // no erase: directed special values and boundaries plus random (R9, R10)
    rand_init(); n_img = 0;
    add_entry(1'b1, 1'b0, 0, 8'h00);
    add_entry(1'b1, 1'b0, 63, 8'hFF);
    add_entry(1'b0, 1'b0, 0, 8'hFF);
    add_entry(1'b0, 1'b1, 511, 8'h5A);
    add_entry(1'b1, 1'b0, 17, 8'hA5);
    add_entry(1'b0, 1'b0, 256, 8'h00);
    add_random(16);
    run(1'b0, 0, 0, "program");
    chk(n_ph > 0, "R9 polling read seen during busy", n_ph, 1);

    // verify failure on a fixed-wait value (R11)
    rand_init(); n_img = 0; add_entry(1'b0, 1'b1, 5, 8'hFF); add_entry(1'b1, 1'b0, 9, 8'h33);
    run(1'b0, 1, 2, "verify-fail");
    chk(n_wr == 1, "R11 stop after mismatch", n_wr, 1);

    // target never completes (R9)
    rand_init(); n_img = 0; add_entry(1'b1, 1'b0, 12, 8'h5A);
    run(1'b0, 2, 1, "timeout");
    chk(n_rd == PMAX, "R9 poll attempts", n_rd, PMAX);

    // empty image ends right after enable (R6)
    rand_init(); n_img = 0;
    run(1'b0, 0, 0, "empty");
    chk(n_wr == 0, "R6 empty image", n_wr, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(190000 * 5);
    chk(1'b0, "R12 global watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule